// File: doc/BRIEF.md
# Bit-Sliced Integer ALU

A combinational arithmetic logic unit for a 32-bit integer datapath (the width is a parameter). It takes two operands and a 4-bit operation code. It returns a result word together with carry-out, signed overflow and zero flags.

The word is built from identical one-bit slices joined by a ripple carry chain. Each slice has an AND path, an OR path and a full-adder sum. A four-way selector picks one of these or a "less" input. The operation code is split into three fields:
- bit 3 inverts operand A before it reaches every slice;
- bit 2 inverts operand B and also forces the carry into bit 0;
- bits 1:0 choose which slice path drives the result.

Subtraction, NOR and the signed less-than compare all come from these field settings. For the compare, the sign of A minus B is taken from the top slice, corrected for overflow, and fed back into the "less" input of bit 0. Every other slice sees a constant zero there.

Top module: `int_alu`

## Requirements
- R1: Code 0000 drives result = A AND B.
- R2: Code 0001 drives result = A OR B.
- R3: Code 0010 drives result = (A + B) mod 2^W, and carry_out is the unsigned carry out of that addition.
- R4: Code 0110 drives result = (A - B) mod 2^W, and carry_out is 1 exactly when A >= B as unsigned numbers (no borrow).
- R5: For codes 0010 and 0110, overflow is 1 exactly when the two's-complement result does not fit in W bits. That is, the operands seen by the adder share a sign and the result sign differs from it.
- R6: Code 1100 drives result = NOT(A OR B).
- R7: Code 0111 drives result bit 0 to 1 when A < B as signed numbers and to 0 otherwise, with all higher result bits 0. This holds even when A - B overflows.
- R8: For every code, zero is 1 exactly when all result bits are 0.
- R9: Any code is decoded field by field: bit 3 inverts A, bit 2 inverts B and sets the bit-0 carry-in, and bits 1:0 select the path (00 AND, 01 OR, 10 sum, 11 less). For example, 0100 gives A AND NOT B, and 1101 gives NOT A OR NOT B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand |
| op_code | input | 4 | Operation code (inversion fields and path select) |
| result | output | WIDTH | Selected result word |
| carry_out | output | 1 | Carry out of the top slice |
| overflow | output | 1 | Carry into the top slice XOR carry out of it |
| zero | output | 1 | High when every result bit is 0 |

## Verification
The hardest case to reach is a signed compare whose internal subtraction overflows. Here the raw sign of A - B gives the wrong answer, and only the overflow correction on the fed-back bit rescues it. The stimulus reaches it with operand pairs of opposite sign at the ends of the range: the most negative value against small positives, and the most positive value against negative ones. These are checked beside equal and adjacent pairs.

A second hard case is the full-length carry ripple. It is driven by all-ones plus one and by subtracting equal operands. In both, every slice propagates and the zero flag rises together with the carry-out.

// File: rtl/alu_pkg.sv
package alu_pkg;

   localparam int unsigned OP_W = 4;

   typedef enum logic [1:0] {
      PATH_AND  = 2'b00,
      PATH_OR   = 2'b01,
      PATH_SUM  = 2'b10,
      PATH_LESS = 2'b11
   } path_e;

   typedef struct packed {
      logic  inv_a;
      logic  neg_b;
      path_e path;
   } slice_ctl_t;

   localparam logic [OP_W-1:0] OPC_AND = 4'b0000;
   localparam logic [OP_W-1:0] OPC_OR  = 4'b0001;
   localparam logic [OP_W-1:0] OPC_ADD = 4'b0010;
   localparam logic [OP_W-1:0] OPC_SUB = 4'b0110;
   localparam logic [OP_W-1:0] OPC_SLT = 4'b0111;
   localparam logic [OP_W-1:0] OPC_NOR = 4'b1100;

endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
   import alu_pkg::*;
(
   input  logic [OP_W-1:0] opcode_i,
   output slice_ctl_t      ctl_o
);

   // Field split: the upper two bits condition the operands and the lower
   // two pick the slice path.
   always_comb begin
      ctl_o.inv_a = opcode_i[3];
      ctl_o.neg_b = opcode_i[2];
      ctl_o.path  = path_e'(opcode_i[1:0]);
   end

endmodule

// File: rtl/alu_ripple_chain.sv
module alu_ripple_chain #(
   parameter int unsigned W = 32
) (
   input  logic [W-1:0] x_i,
   input  logic [W-1:0] y_i,
   input  logic         cin_i,
   output logic [W:0]   carry_o
);

   // Carry for each bit position, evaluated serially from bit 0 upward.
   always_comb begin
      logic [W:0] c;
      c[0] = cin_i;
      for (int i = 0; i < int'(W); i++) begin
         c[i+1] = (x_i[i] & y_i[i]) | ((x_i[i] ^ y_i[i]) & c[i]);
      end
      carry_o = c;
   end

endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
   import alu_pkg::*;
(
   input  logic  x_i,
   input  logic  y_i,
   input  logic  cin_i,
   input  logic  less_i,
   input  path_e path_i,
   output logic  res_o,
   output logic  sum_o
);

   always_comb begin
      sum_o = x_i ^ y_i ^ cin_i;
      case (path_i)
         PATH_AND:  res_o = x_i & y_i;
         PATH_OR:   res_o = x_i | y_i;
         PATH_SUM:  res_o = sum_o;
         PATH_LESS: res_o = less_i;
      endcase
   end

endmodule

// File: rtl/int_alu.sv
module int_alu
   import alu_pkg::*;
#(
   parameter int unsigned WIDTH       = 32,
   parameter bit          SLT_OVF_FIX = 1'b1
) (
   input  logic [WIDTH-1:0] opnd_a,
   input  logic [WIDTH-1:0] opnd_b,
   input  logic [OP_W-1:0]  op_code,
   output logic [WIDTH-1:0] result,
   output logic             carry_out,
   output logic             overflow,
   output logic             zero
);

   localparam int unsigned MSB = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("int_alu: WIDTH must be at least 2");
      end
   endgenerate

   slice_ctl_t       ctl;
   logic [WIDTH-1:0] x_cond;
   logic [WIDTH-1:0] y_cond;
   logic [WIDTH:0]   carry;
   logic [WIDTH-1:0] sum_bits;
   logic             set_raw;
   logic             less_bit0;

   alu_op_decode u_dec (
      .opcode_i (op_code),
      .ctl_o    (ctl)
   );

   // Operand conditioning shared by every slice and by the carry chain.
   assign x_cond = opnd_a ^ {WIDTH{ctl.inv_a}};
   assign y_cond = opnd_b ^ {WIDTH{ctl.neg_b}};

   alu_ripple_chain #(.W(WIDTH)) u_chain (
      .x_i     (x_cond),
      .y_i     (y_cond),
      .cin_i   (ctl.neg_b),
      .carry_o (carry)
   );

   assign overflow  = carry[MSB] ^ carry[WIDTH];
   assign carry_out = carry[WIDTH];
   assign set_raw   = sum_bits[MSB];

   generate
      if (SLT_OVF_FIX) begin : g_less_fixed
         assign less_bit0 = set_raw ^ overflow;
      end else begin : g_less_raw
         assign less_bit0 = set_raw;
      end
   endgenerate

   generate
      for (genvar i = 0; i < int'(WIDTH); i++) begin : g_slice
         logic less_in;
         if (i == 0) begin : g_lsb
            assign less_in = less_bit0;
         end else begin : g_upper
            assign less_in = 1'b0;
         end
         alu_bit_slice u_slice (
            .x_i    (x_cond[i]),
            .y_i    (y_cond[i]),
            .cin_i  (carry[i]),
            .less_i (less_in),
            .path_i (ctl.path),
            .res_o  (result[i]),
            .sum_o  (sum_bits[i])
         );
      end
   endgenerate

   assign zero = ~|result;

   // Cross-checks of the sliced datapath against word-level arithmetic.
   always_comb begin
      if (op_code == OPC_AND) begin
         p_and_r1: assert (result == (opnd_a & opnd_b))
            else $error("R1 AND path mismatch");
      end
      if (op_code == OPC_OR) begin
         p_or_r2: assert (result == (opnd_a | opnd_b))
            else $error("R2 OR path mismatch");
      end
      if (op_code == OPC_ADD) begin
         p_add_r3: assert ({carry_out, result} ==
                           ({1'b0, opnd_a} + {1'b0, opnd_b}) && result == sum_bits)
            else $error("R3 add mismatch");
         p_add_ovf_r5: assert (overflow ==
                               ((opnd_a[MSB] == opnd_b[MSB]) && (result[MSB] != opnd_a[MSB])))
            else $error("R5 add overflow mismatch");
      end
      if (op_code == OPC_SUB) begin
         p_sub_r4: assert (result == (opnd_a - opnd_b) && carry_out == (opnd_a >= opnd_b))
            else $error("R4 subtract mismatch");
         p_sub_ovf_r5: assert (overflow ==
                               ((opnd_a[MSB] != opnd_b[MSB]) && (result[MSB] != opnd_a[MSB])))
            else $error("R5 subtract overflow mismatch");
      end
      if (op_code == OPC_SLT && SLT_OVF_FIX) begin
         p_slt_r7: assert (result[MSB:1] == '0 &&
                           result[0] == ($signed(opnd_a) < $signed(opnd_b)))
            else $error("R7 set-on-less-than mismatch");
      end
      if (op_code == OPC_NOR) begin
         p_nor_r6: assert (result == ~(opnd_a | opnd_b))
            else $error("R6 NOR mismatch");
      end
   end

endmodule

// File: tb/sim_int_alu.sv
`timescale 1ns/1ps
module sim_int_alu;

   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] a = '0;
   logic [W-1:0] b = '0;
   logic [3:0]   op = 4'b0000;
   logic [W-1:0] result;
   logic         carry_out, overflow, zero;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   int_alu u0 (
      .opnd_a    (a),
      .opnd_b    (b),
      .op_code   (op),
      .result    (result),
      .carry_out (carry_out),
      .overflow  (overflow),
      .zero      (zero)
   );

   function automatic logic [W-1:0] ref_res(input logic [3:0] o, input logic [W-1:0] x,
                                            input logic [W-1:0] y);
      case (o)
         4'b0000: return x & y;
         4'b0001: return x | y;
         4'b0010: return x + y;
         4'b0110: return x - y;
         4'b0111: return ($signed(x) < $signed(y)) ? W'(1) : W'(0);
         4'b1100: return ~(x | y);
         4'b0100: return x & ~y;
         4'b1101: return ~x | ~y;
         default: return 'x;
      endcase
   endfunction

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s op=%b a=%h b=%h actual=%h expected=%h", req, op, a, b, act, exp);
      end
   endtask

   // Apply after a rising edge, sample at the following falling edge.
   task automatic apply(input logic [3:0] o, input logic [W-1:0] x, input logic [W-1:0] y);
      @(posedge clk);
      #1;
      op = o; a = x; b = y;
      @(negedge clk);
   endtask

   task automatic run_op(input string req, input logic [3:0] o,
                         input logic [W-1:0] x, input logic [W-1:0] y);
      logic [W-1:0] e;
      apply(o, x, y);
      e = ref_res(o, x, y);
      chk(req, result, e);
      chk("R8", W'(zero), W'(e == '0));
      if (o == 4'b0010) begin
         chk("R3 carry", W'(carry_out), W'((({1'b0, x} + {1'b0, y}) >> W) & 1));
         chk("R5 add", W'(overflow), W'((x[W-1] == y[W-1]) && (e[W-1] != x[W-1])));
      end
      if (o == 4'b0110) begin
         chk("R4 carry", W'(carry_out), W'(x >= y));
         chk("R5 sub", W'(overflow), W'((x[W-1] != y[W-1]) && (e[W-1] != x[W-1])));
      end
   endtask

   task automatic t_idle;
      apply(4'b0000, '0, '0);
      chk("R1 idle", result, '0);
      chk("R8 idle", W'(zero), W'(1));
   endtask

   task automatic t_logic;
      run_op("R1", 4'b0000, 32'hF0F0_1234, 32'hFF00_0F0F);
      run_op("R1", 4'b0000, 32'hAAAA_AAAA, 32'h5555_5555);
      run_op("R2", 4'b0001, 32'h0000_00F0, 32'h8000_000F);
      run_op("R2", 4'b0001, 32'h0, 32'h0);
      run_op("R6", 4'b1100, 32'h0F0F_0000, 32'h0000_F0F0);
      run_op("R6", 4'b1100, 32'hFFFF_FFFF, 32'h0);
   endtask

   task automatic t_add;
      run_op("R3", 4'b0010, 32'd100, 32'd23);
      run_op("R3", 4'b0010, 32'hFFFF_FFFF, 32'd1);
      run_op("R5", 4'b0010, 32'h7FFF_FFFF, 32'd1);
      run_op("R5", 4'b0010, 32'h8000_0000, 32'h8000_0000);
      run_op("R3", 4'b0010, 32'hFFFF_FFFE, 32'hFFFF_FFFF);
   endtask

   task automatic t_sub;
      run_op("R4", 4'b0110, 32'd5, 32'd5);
      run_op("R4", 4'b0110, 32'd3, 32'd5);
      run_op("R5", 4'b0110, 32'h8000_0000, 32'd1);
      run_op("R5", 4'b0110, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
      run_op("R4", 4'b0110, 32'hDEAD_BEEF, 32'h1234_5678);
   endtask

   task automatic t_slt;
      run_op("R7", 4'b0111, 32'd1, 32'd2);
      run_op("R7", 4'b0111, 32'd2, 32'd1);
      run_op("R7", 4'b0111, 32'd9, 32'd9);
      run_op("R7", 4'b0111, 32'hFFFF_FFFF, 32'd0);
      run_op("R7 ovf", 4'b0111, 32'h8000_0000, 32'd1);
      run_op("R7 ovf", 4'b0111, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
      run_op("R7 ovf", 4'b0111, 32'h7FFF_FFFF, 32'h8000_0000);
      run_op("R7 ovf", 4'b0111, 32'h8000_0000, 32'h7FFF_FFFF);
   endtask

   task automatic t_fields;
      run_op("R9", 4'b0100, 32'hFFFF_00FF, 32'h0F0F_0F0F);
      run_op("R9", 4'b1101, 32'hFFFF_0000, 32'hFF00_FF00);
      run_op("R9", 4'b1101, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
   endtask

   task automatic t_sweep;
      logic [W-1:0] s = 32'h1357_9BDF;
      logic [3:0] codes [6] = '{4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111, 4'b1100};
      for (int n = 0; n < 120; n++) begin
         logic [W-1:0] x, y;
         s = {s[W-2:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
         x = s;
         s = {s[W-2:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
         y = s ^ 32'h9E37_79B9;
         run_op("R1-sweep R3 R4 R7", codes[n % 6], x, y);
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      t_idle();
      t_logic();
      t_add();
      t_sub();
      t_slt();
      t_fields();
      t_sweep();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule